// File: doc/BRIEF.md
# Packed Signed Byte Compare Unit

This unit compares two 128-bit vectors lane by lane. Each vector holds sixteen two's-complement bytes. A 3-bit predicate code picks one of eight tests: the four orderings, equality, inequality, and two constants. The test is always the first source against the second. Each lane produces a byte mask: all ones when the test holds and all zeros when it fails.

The masks are captured into a 256-bit destination image one clock after the input strobe. Every write clears the upper 128 bits of that image, so the image reads as a narrow result that has been zero-extended into a wide register. The unit has no condition flags.

Instruction decode, operand fetch, register file access and fault handling belong to the surrounding pipeline.

Top module: `byte_cmp_unit`

## Requirements
- R1: Lane i of the result, bits [8i+7:8i] of `dest`, depends only on bits [8i+7:8i] of `src_a` and `src_b`, for i = 0 to 15.
- R2: Each lane is compared as a signed byte, `src_a` lane against `src_b` lane. Predicate codes `sel[2:0]` are: 0 = less than, 1 = less or equal, 2 = greater than, 3 = greater or equal.
- R3: Predicate code 4 tests equality and code 5 tests inequality.
- R4: Predicate code 6 yields all-zero lanes and code 7 yields all-ones lanes, whatever the sources hold.
- R5: Every written lane byte is either 8'hFF (test true) or 8'h00 (test false).
- R6: Bits `sel[7:3]` have no effect on the result.
- R7: After every write, `dest[255:128]` is zero.
- R8: When `in_valid` is high at a rising edge, `dest` takes the new result at that edge and `out_valid` is high for exactly the following cycle. When `in_valid` is low at an edge, `dest` holds its value and `out_valid` is low.
- R9: While `rst_n` is low, `dest` is cleared to zero and `out_valid` is low.
- R10: The ordering is correct at the extremes. For example, 8'h80 (-128) is less than 8'h7F (+127) in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| in_valid | input | 1 | Strobe that marks the sources and selector as valid |
| src_a | input | 128 | First source vector, sixteen signed bytes |
| src_b | input | 128 | Second source vector, sixteen signed bytes |
| sel | input | 8 | Selector byte; only bits [2:0] pick the predicate |
| dest | output | 256 | Destination image: lane masks in [127:0], zero in [255:128] |
| out_valid | output | 1 | High for the one cycle after a write |

## Verification
The properties assume that `src_a`, `src_b` and `sel` are stable and known at every edge where `in_valid` is high. They also assume that `in_valid` itself is never unknown after reset.

The stimulus changes inputs only on falling edges and clears `in_valid` between operations. The sources are drawn at random, then lanes are forced equal or set to the signed extremes often enough that the equality and boundary tests get exercised. The upper selector bits are randomised on every operation.

// File: rtl/cmpb_pkg.sv
`timescale 1ns/1ps
package cmpb_pkg;
  localparam int BYTE_W = 8;
  localparam int PRED_W = 3;

  typedef enum logic [PRED_W-1:0] {
    P_LT     = 3'd0,
    P_LE     = 3'd1,
    P_GT     = 3'd2,
    P_GE     = 3'd3,
    P_EQ     = 3'd4,
    P_NE     = 3'd5,
    P_NEVER  = 3'd6,
    P_ALWAYS = 3'd7
  } pred_t;

  // Signed less-than, taken from the sign of a sign-extended difference.
  function automatic logic s_less(input logic [BYTE_W-1:0] a,
                                  input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0] diff;
    diff = {a[BYTE_W-1], a} - {b[BYTE_W-1], b};
    return diff[BYTE_W];
  endfunction

  function automatic logic pred_eval(input pred_t p,
                                     input logic lt,
                                     input logic eq);
    logic r;
    unique case (p)
      P_LT:     r = lt;
      P_LE:     r = lt | eq;
      P_GT:     r = ~(lt | eq);
      P_GE:     r = ~lt;
      P_EQ:     r = eq;
      P_NE:     r = ~eq;
      P_NEVER:  r = 1'b0;
      default:  r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cmpb_decode.sv
`timescale 1ns/1ps
module cmpb_decode
  import cmpb_pkg::*;
(
  input  logic [PRED_W-1:0] code,
  output pred_t             pred
);
  always_comb pred = pred_t'(code);
endmodule

// File: rtl/cmpb_lane.sv
`timescale 1ns/1ps
module cmpb_lane
  import cmpb_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  pred_t             pred,
  output logic              hit,
  output logic [BYTE_W-1:0] mask
);
  logic lt_w;
  logic eq_w;

  always_comb begin
    lt_w = s_less(a, b);
    eq_w = (a == b);
    hit  = pred_eval(pred, lt_w, eq_w);
    mask = {BYTE_W{hit}};
  end
endmodule

// File: rtl/cmpb_array.sv
`timescale 1ns/1ps
module cmpb_array
  import cmpb_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VEC_W = LANES * BYTE_W
) (
  input  logic [VEC_W-1:0] va,
  input  logic [VEC_W-1:0] vb,
  input  pred_t            pred,
  output logic [LANES-1:0] hits,
  output logic [VEC_W-1:0] masks
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cmpb_lane u_lane (
      .a    (va[g*BYTE_W +: BYTE_W]),
      .b    (vb[g*BYTE_W +: BYTE_W]),
      .pred (pred),
      .hit  (hits[g]),
      .mask (masks[g*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/byte_cmp_unit.sv
`timescale 1ns/1ps
module byte_cmp_unit
  import cmpb_pkg::*;
#(
  parameter int LANES = 16,
  parameter int SEL_W = 8,
  localparam int VEC_W  = LANES * BYTE_W,
  localparam int DEST_W = 2 * VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [SEL_W-1:0]  sel,
  output logic [DEST_W-1:0] dest,
  output logic              out_valid
);
  pred_t            pred_w;
  logic [LANES-1:0] lane_hit;
  logic [VEC_W-1:0] lane_mask;
  logic             write_ev;

  assign write_ev = in_valid;

  cmpb_decode u_dec (
    .code (sel[PRED_W-1:0]),
    .pred (pred_w)
  );

  cmpb_array #(.LANES(LANES)) u_arr (
    .va    (src_a),
    .vb    (src_b),
    .pred  (pred_w),
    .hits  (lane_hit),
    .masks (lane_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= write_ev;
      if (write_ev) dest <= {{VEC_W{1'b0}}, lane_mask};
    end
  end
endmodule

// File: rtl/cmpb_checker.sv
`timescale 1ns/1ps
module cmpb_checker #(
  parameter int LANES = 16,
  parameter int SEL_W = 8,
  localparam int VEC_W  = LANES * 8,
  localparam int DEST_W = 2 * VEC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [VEC_W-1:0]  src_a,
  input logic [VEC_W-1:0]  src_b,
  input logic [SEL_W-1:0]  sel,
  input logic [DEST_W-1:0] dest,
  input logic              out_valid
);
  function automatic logic masks_clean(input logic [VEC_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  // R5
  a_r5_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> masks_clean(dest[VEC_W-1:0]));
  // R7
  a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dest[DEST_W-1:VEC_W] == '0);
  // R8
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dest));
  // R4
  a_r4_never: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel[2:0] == 3'd6) |=> dest[VEC_W-1:0] == '0);
  a_r4_always: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel[2:0] == 3'd7) |=> dest[VEC_W-1:0] == '1);
  // R3
  a_r3_eq_same: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel[2:0] == 3'd4 && src_a == src_b) |=> dest[VEC_W-1:0] == '1);
  a_r3_ne_same: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel[2:0] == 3'd5 && src_a == src_b) |=> dest[VEC_W-1:0] == '0);
  // R10
  a_r10_extreme_lt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel[2:0] == 3'd0 && src_a == {LANES{8'h80}} && src_b == {LANES{8'h7F}})
      |=> dest[VEC_W-1:0] == '1);
endmodule

bind byte_cmp_unit cmpb_checker #(.LANES(LANES), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .src_a     (src_a),
  .src_b     (src_b),
  .sel       (sel),
  .dest      (dest),
  .out_valid (out_valid)
);

// File: tb/sim_byte_cmp_unit.sv
`timescale 1ns/1ps
module sim_byte_cmp_unit;
  localparam int L = 16;
  localparam int VW = L * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic [7:0]    sel = '0;
  logic [2*VW-1:0] dest;
  logic          out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_cmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .sel(sel),
    .dest(dest), .out_valid(out_valid)
  );

  // Reference model: integer compare of signed lane values.
  function automatic logic [VW-1:0] model(input logic [VW-1:0] a,
                                          input logic [VW-1:0] b,
                                          input logic [7:0] s);
    logic [VW-1:0] r;
    for (int i = 0; i < L; i++) begin
      int x;
      int y;
      bit t;
      x = int'($signed(a[i*8 +: 8]));
      y = int'($signed(b[i*8 +: 8]));
      case (s % 8)
        0: t = x <  y;
        1: t = x <= y;
        2: t = x >  y;
        3: t = x >= y;
        4: t = x == y;
        5: t = x != y;
        6: t = 0;
        default: t = 1;
      endcase
      r[i*8 +: 8] = t ? 8'hFF : 8'h00;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [2*VW-1:0] got,
                       input logic [2*VW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Apply one operation, check result one cycle later and hold afterwards.
  task automatic run_op(input string req, input logic [VW-1:0] a,
                        input logic [VW-1:0] b, input logic [7:0] s);
    logic [2*VW-1:0] exp;
    exp = {{VW{1'b0}}, model(a, b, s)};
    @(negedge clk);
    src_a = a; src_b = b; sel = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    src_a = ~a; src_b = a; sel = ~s;
    check(req, dest, exp);                     // R2..R7 per caller tag
    check("R8 valid pulse", {255'd0, out_valid}, 256'd1);
    @(negedge clk);
    check("R8 hold", {dest[2*VW-1:1], out_valid}, {exp[2*VW-1:1], 1'b0});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a;
    logic [VW-1:0] b;
    logic [2*VW-1:0] r1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 reset dest", dest, '0);
    check("R9 reset valid", {255'd0, out_valid}, 256'd0);
    rst_n = 1'b1;

    // R10 extremes, every ordering predicate
    for (int p = 0; p < 4; p++)
      run_op("R10 extremes", {L{8'h80}}, {L{8'h7F}}, 8'(p));
    run_op("R10 reversed", {L{8'h7F}}, {L{8'h80}}, 8'd0);
    // R1 single-lane difference
    for (int k = 0; k < L; k += 5) begin
      b = '0;
      b[k*8 +: 8] = 8'h01;
      run_op("R1 lane map", '0, b, 8'd0);
    end
    // R3 equal operands and R4 constants
    a = {$urandom, $urandom, $urandom, $urandom};
    run_op("R3 eq", a, a, 8'd4);
    run_op("R3 ne", a, a, 8'd5);
    run_op("R4 never", a, ~a, 8'd6);
    run_op("R4 always", a, ~a, 8'd7);
    // R6 upper selector bits ignored
    b = {$urandom, $urandom, $urandom, $urandom};
    run_op("R6 base", a, b, 8'h01);
    r1 = dest;
    run_op("R6 upper bits", a, b, 8'hF9);
    check("R6 same result", dest, r1);
    // R7 upper half cleared even after reset-free history
    run_op("R7 upper zero", '1, '0, 8'd7);

    // Random mix for R2 and R5
    for (int n = 0; n < 300; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < L; i++) begin
        int c;
        c = $urandom % 6;
        if (c == 0) b[i*8 +: 8] = a[i*8 +: 8];
        else if (c == 1) a[i*8 +: 8] = 8'h80;
        else if (c == 2) b[i*8 +: 8] = 8'h7F;
      end
      run_op("R2 R5 random", a, b, 8'($urandom));
    end

    // R9 reset mid-stream clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears", dest, '0);
    rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule